// File: doc/BRIEF.md
# Converter Sequencer with Shadowed Channel Select

This block runs the control side of an 8-bit converter. Software writes a requested channel into a holding register. A second register, the shadow, drives the analog multiplexer select. The sequencer decides on which converter clock ticks the shadow may copy the holding register. While the converter is idle, the shadow copies it on every tick. It stops copying when a conversion starts, which keeps the sampling window fixed. It copies once more on the tick that completes the conversion.

Conversions are started in one of three ways: by software (single shot), by the completion of the previous conversion (free running), or by a pulse on an external trigger pin. The converter clock is a one-cycle enable, `adc_ce`, that is qualified against the system clock. A conversion lasts 13 converter cycles. The block latches the channel's raw sample near the start of the conversion. When the conversion completes, it turns that sample into an 8-bit code, stores the code in the result register and raises a completion flag. The raw sample for each channel comes in on a flattened sample bus.

Top module: `adc_seq`

## Requirements
- R1: Writes use `wr_addr` to pick a register. Address 1 holds the requested channel, taken from the low `wr_data` bits and visible on `chan_req` from the clock after the write. Address 0 is the control register: bit 0 enable, bit 1 go, bit 2 auto-trigger, bit 3 free-run (1 = restart on completion, 0 = external trigger), and bit 4 flag-clear, which acts only when written as 1.
- R2: While no conversion is running, `mux_sel` takes the value of `chan_req` on every `adc_ce` tick and keeps its old value between ticks.
- R3: Writing go=1 together with enable=1 while idle sets `busy` from the clock after the write. The conversion begins on the first `adc_ce` tick after the write. The completion flag rises on the 14th tick counted from the write, so the conversion spans 13 converter cycles.
- R4: From the tick that starts a conversion until its 13th cycle, `mux_sel` ignores changes to `chan_req`. On the completing tick, `mux_sel` loads `chan_req` again.
- R5: The raw sample of the channel on `mux_sel` is latched on the tick that ends converter cycle 2. Changes to the sample input after that point do not alter the result.
- R6: A sample s below the reference level of 1024 converts to floor(s*256/1024). A sample of 1024 or more converts to 0xFF. `result` changes only on a completing tick.
- R7: In single-shot mode (auto-trigger 0), `busy` returns to 0 on the completing tick.
- R8: When enable, auto-trigger and free-run are all 1, a new conversion starts on the completing tick with the shadow value loaded on that tick. A channel written after a completion therefore first shows up in the result of the conversion after the one already running.
- R9: Clearing auto-trigger or enable during free running lets the current conversion finish. No new one starts, and `busy` falls on that completion.
- R10: When enable and auto-trigger are 1 and free-run is 0, a `trig` pulse seen while idle starts a conversion on the next tick. A pulse while `busy` is 1 is ignored. A pulse with auto-trigger 0 is ignored.
- R11: `done_flag` rises on each completing tick. Writing control with flag-clear=1 clears it, and writing with flag-clear=0 leaves it set. If a completion and a clear fall on the same clock, the completion wins.
- R12: After reset, `mux_sel`, `chan_req`, `result`, `done_flag` and `busy` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| adc_ce | input | 1 | One-cycle converter clock tick |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = control, 1 = channel |
| wr_data | input | 8 | Write data |
| trig | input | 1 | External trigger pulse |
| samples | input | NCH*SW (44) | Raw sample for each channel, channel 0 in the low bits |
| mux_sel | output | CH_W (2) | Shadow channel select driving the multiplexer |
| chan_req | output | CH_W (2) | Channel holding register as last written |
| result | output | 8 | Last conversion code |
| done_flag | output | 1 | Completion flag |
| busy | output | 1 | Go bit read-back: a conversion is pending or running |

## Verification
The bench counts converter ticks between the go write and the flag. A start one tick early or late, or a conversion of the wrong length, shows up as a count other than 14. It changes the requested channel and the sample value partway through a conversion. A shadow that is not frozen would then report the new channel or a late sample. In free running, it writes a new channel right after a completion and expects the next result to still carry the old channel. A shadow that loads at restart instead of at completion gives the new channel one conversion too early. Samples of 1020, 1024 and 1100 separate correct saturation from a code that wraps in its low bits. Trigger pulses sent while busy, or with auto-trigger off, must leave the flag low and `busy` at 0.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  // control register bit positions
  localparam int CB_EN   = 0;
  localparam int CB_GO   = 1;
  localparam int CB_AUTO = 2;
  localparam int CB_FREE = 3;
  localparam int CB_CLR  = 4;

  localparam logic A_CTRL = 1'b0;
  localparam logic A_CHAN = 1'b1;

  typedef struct packed {
    logic free;
    logic autotrig;
    logic en;
  } mode_t;

  // sample to 8-bit code with saturation at the reference level
  function automatic logic [7:0] to_code(input int unsigned s, input int unsigned ref_lvl);
    int unsigned q;
    if (s >= ref_lvl) return 8'hFF;
    q = (s * 256) / ref_lvl;
    return q[7:0];
  endfunction
endpackage

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
  import adc_seq_pkg::*;
#(
  parameter int CH_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            wr_addr,
  input  logic [7:0]      wr_data,
  input  logic            conv_done,
  output mode_t           mode,
  output logic [CH_W-1:0] chan_req,
  output logic            go_wr,
  output logic            flag
);
  logic ctrl_wr, chan_wr, clr_wr;
  logic unused_hi;

  assign ctrl_wr   = wr_en && (wr_addr == A_CTRL);
  assign chan_wr   = wr_en && (wr_addr == A_CHAN);
  assign clr_wr    = ctrl_wr && wr_data[CB_CLR];
  assign go_wr     = ctrl_wr && wr_data[CB_GO] && wr_data[CB_EN];
  assign unused_hi = ^wr_data[7:5];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode     <= '0;
      chan_req <= '0;
      flag     <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        mode.en       <= wr_data[CB_EN];
        mode.autotrig <= wr_data[CB_AUTO];
        mode.free     <= wr_data[CB_FREE];
      end
      if (chan_wr) chan_req <= wr_data[CH_W-1:0];
      if (conv_done)   flag <= 1'b1;
      else if (clr_wr) flag <= 1'b0;
    end
  end

  // R1
  chan_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chan_wr |=> chan_req == $past(wr_data[CH_W-1:0]));
  // R11
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> flag);
  // R11
  flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !conv_done) |=> !flag);
endmodule

// File: rtl/adc_seq_timer.sv
module adc_seq_timer
  import adc_seq_pkg::*;
#(
  parameter int CONV_CYC   = 13,
  parameter int SAMPLE_CYC = 2
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ce,
  input  mode_t mode,
  input  logic  go_wr,
  input  logic  trig,
  output logic  active,
  output logic  busy,
  output logic  conv_start,
  output logic  conv_done,
  output logic  sample_stb,
  output logic  trk
);
  localparam int CNT_W = $clog2(CONV_CYC + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CONV_CYC);
  localparam logic [CNT_W-1:0] SMP  = CNT_W'(SAMPLE_CYC);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt;
  logic start_req;
  logic ext_ok, run_free, trig_acc, restart;

  assign ext_ok     = mode.en && mode.autotrig && !mode.free;
  assign run_free   = mode.en && mode.autotrig && mode.free;
  assign busy       = start_req || active;
  assign trig_acc   = trig && ext_ok;
  assign conv_start = ce && !active && start_req;
  assign conv_done  = ce && active && (cnt == LAST);
  assign restart    = conv_done && run_free;
  assign sample_stb = ce && active && (cnt == SMP);
  assign trk        = ce && (!active || conv_done);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      cnt       <= '0;
      start_req <= 1'b0;
    end else begin
      if (conv_start) begin
        active <= 1'b1;
        cnt    <= ONE;
      end else if (conv_done) begin
        if (restart) cnt <= ONE;
        else begin
          active <= 1'b0;
          cnt    <= '0;
        end
      end else if (ce && active) begin
        cnt <= cnt + ONE;
      end

      if (conv_done && !restart)             start_req <= 1'b0;
      else if ((go_wr || trig_acc) && !busy) start_req <= 1'b1;
    end
  end

  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (cnt >= ONE && cnt <= LAST));
  // R3
  go_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go_wr && !busy) |=> busy);
  // R7
  single_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && !restart) |=> !busy);
  // R8
  free_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (active && cnt == ONE));
  // R10
  ext_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_ok && !go_wr && !busy) |=> !busy);
endmodule

// File: rtl/adc_seq_chan.sv
module adc_seq_chan
  import adc_seq_pkg::*;
#(
  parameter int NCH     = 4,
  parameter int CH_W    = 2,
  parameter int SW      = 11,
  parameter int REF_LVL = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trk,
  input  logic              active,
  input  logic              sample_stb,
  input  logic              conv_done,
  input  logic [CH_W-1:0]   chan_req,
  input  logic [NCH*SW-1:0] samples,
  output logic [CH_W-1:0]   mux_sel,
  output logic [7:0]        result
);
  logic [SW-1:0] smp_arr [NCH];
  logic [SW-1:0] picked;
  logic [SW-1:0] samp_q;

  for (genvar g = 0; g < NCH; g++) begin : g_unpack
    assign smp_arr[g] = samples[g*SW +: SW];
  end

  always_comb begin
    picked = '0;
    for (int i = 0; i < NCH; i++)
      if (mux_sel == CH_W'(i)) picked = smp_arr[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mux_sel <= '0;
      samp_q  <= '0;
      result  <= '0;
    end else begin
      if (trk)        mux_sel <= chan_req;
      if (sample_stb) samp_q  <= picked;
      if (conv_done)  result  <= to_code(32'(samp_q), REF_LVL);
    end
  end

  // R2
  track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trk |=> mux_sel == $past(chan_req));
  // R4
  frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !trk) |=> $stable(mux_sel));
  // R5
  sample_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_stb |=> $stable(samp_q));
  // R6
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_done |=> $stable(result));
endmodule

// File: rtl/adc_seq.sv
module adc_seq
  import adc_seq_pkg::*;
#(
  parameter int NCH        = 4,
  parameter int SW         = 11,
  parameter int REF_LVL    = 1024,
  parameter int CONV_CYC   = 13,
  parameter int SAMPLE_CYC = 2,
  localparam int CH_W      = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adc_ce,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              trig,
  input  logic [NCH*SW-1:0] samples,
  output logic [CH_W-1:0]   mux_sel,
  output logic [CH_W-1:0]   chan_req,
  output logic [7:0]        result,
  output logic              done_flag,
  output logic              busy
);
  mode_t mode;
  logic  go_wr, active, conv_start, conv_done, sample_stb, trk;

  adc_seq_regs #(.CH_W(CH_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .conv_done(conv_done), .mode(mode),
    .chan_req(chan_req), .go_wr(go_wr), .flag(done_flag)
  );

  adc_seq_timer #(.CONV_CYC(CONV_CYC), .SAMPLE_CYC(SAMPLE_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .ce(adc_ce), .mode(mode), .go_wr(go_wr),
    .trig(trig), .active(active), .busy(busy), .conv_start(conv_start),
    .conv_done(conv_done), .sample_stb(sample_stb), .trk(trk)
  );

  adc_seq_chan #(.NCH(NCH), .CH_W(CH_W), .SW(SW), .REF_LVL(REF_LVL)) u_chan (
    .clk(clk), .rst_n(rst_n), .trk(trk), .active(active),
    .sample_stb(sample_stb), .conv_done(conv_done), .chan_req(chan_req),
    .samples(samples), .mux_sel(mux_sel), .result(result)
  );

  // R3
  start_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> (busy && mux_sel == $past(chan_req)));
endmodule

// File: tb/tb_adc_seq.sv
module tb_adc_seq;
  localparam int NCH = 4;
  localparam int SW  = 11;
  localparam int CHW = 2;
  localparam logic [7:0] EN = 8'h01, GO = 8'h02, AUT = 8'h04, FRE = 8'h08, CLR = 8'h10;

  logic clk = 1'b0, rst_n = 1'b0, adc_ce = 1'b0, wr_en = 1'b0, wr_addr = 1'b0, trig = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [SW-1:0] smp [NCH];
  wire  [NCH*SW-1:0] samples = {smp[3], smp[2], smp[1], smp[0]};
  logic [CHW-1:0] mux_sel, chan_req;
  logic [7:0] result;
  logic done_flag, busy;

  int checks = 0, errors = 0, ticks = 0;

  adc_seq dut (
    .clk(clk), .rst_n(rst_n), .adc_ce(adc_ce), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .trig(trig), .samples(samples), .mux_sel(mux_sel),
    .chan_req(chan_req), .result(result), .done_flag(done_flag), .busy(busy)
  );

  always #10 clk = ~clk;
  always @(posedge clk) if (adc_ce) ticks <= ticks + 1;

  initial begin
    int ph = 0;
    forever begin
      @(negedge clk);
      ph = (ph + 1) % 4;
      adc_ce = (ph == 0) && rst_n;
    end
  end

  function automatic int exp_code(input int s);
    return (s > 1023) ? 255 : (s >> 2);
  endfunction

  task automatic report();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_trig();
    @(negedge clk); trig = 1'b1;
    @(negedge clk); trig = 1'b0;
  endtask

  task automatic wait_ticks(input int n);
    int t0 = ticks;
    while (ticks < t0 + n) @(negedge clk);
  endtask

  task automatic wait_flag(input string tag);
    int t0 = ticks;
    while (!done_flag && ticks < t0 + 40) @(negedge clk);
    chk(tag, int'(done_flag), 1);
  endtask

  task automatic t_reset();
    chk("R12 mux_sel", int'(mux_sel), 0);
    chk("R12 chan_req", int'(chan_req), 0);
    chk("R12 result", int'(result), 0);
    chk("R12 flag", int'(done_flag), 0);
    chk("R12 busy", int'(busy), 0);
  endtask

  task automatic t_track();
    wr(1'b1, 8'd2);
    chk("R1 chan_req after write", int'(chan_req), 2);
    chk("R2 shadow not yet loaded", int'(mux_sel), 0);
    wait_ticks(1);
    chk("R2 shadow follows on tick", int'(mux_sel), 2);
  endtask

  task automatic t_single();
    int t0;
    smp[1] = 11'd400;
    wr(1'b1, 8'd1);
    wait_ticks(1);
    wr(1'b0, EN | GO);
    t0 = ticks;
    chk("R3 busy after go", int'(busy), 1);
    while (!done_flag && ticks < t0 + 40) @(negedge clk);
    chk("R3 ticks to flag", ticks - t0, 14);
    chk("R6 result code", int'(result), exp_code(400));
    chk("R7 busy cleared", int'(busy), 0);
    wr(1'b0, EN);
    chk("R11 flag kept on clr=0", int'(done_flag), 1);
    wr(1'b0, EN | CLR);
    chk("R11 flag cleared", int'(done_flag), 0);
  endtask

  task automatic t_freeze();
    int t0;
    smp[1] = 11'd200;
    wr(1'b0, EN | GO);
    t0 = ticks;
    while (ticks < t0 + 2) @(negedge clk);
    wr(1'b1, 8'd3);
    wait_ticks(2);
    chk("R4 shadow frozen", int'(mux_sel), 1);
    smp[1] = 11'd800;
    wait_flag("R3 flag freeze run");
    chk("R5 early sample kept", int'(result), exp_code(200));
    chk("R4 shadow reloaded at end", int'(mux_sel), 3);
    wr(1'b0, EN | CLR);
  endtask

  task automatic conv_once(input int v);
    smp[2] = SW'(v);
    wr(1'b1, 8'd2);
    wait_ticks(1);
    wr(1'b0, EN | GO);
    wait_flag("R3 flag sat run");
    chk($sformatf("R6 code for %0d", v), int'(result), exp_code(v));
    wr(1'b0, EN | CLR);
  endtask

  task automatic t_sat();
    conv_once(0);
    conv_once(4);
    conv_once(1019);
    conv_once(1020);
    conv_once(1024);
    conv_once(1100);
    conv_once(2047);
  endtask

  task automatic t_free();
    smp[0] = 11'd120;
    smp[1] = 11'd600;
    wr(1'b1, 8'd0);
    wait_ticks(1);
    wr(1'b0, EN | AUT | FRE | GO);
    wait_flag("R8 flag first");
    chk("R8 first result", int'(result), exp_code(120));
    wr(1'b0, EN | AUT | FRE | CLR);
    wr(1'b1, 8'd1);
    chk("R8 still running", int'(busy), 1);
    wait_flag("R8 flag second");
    chk("R8 second result old chan", int'(result), exp_code(120));
    wr(1'b0, EN | AUT | FRE | CLR);
    wait_flag("R8 flag third");
    chk("R8 third result new chan", int'(result), exp_code(600));
    wr(1'b0, EN | CLR);
    chk("R9 running one finishes", int'(busy), 1);
    wait_flag("R9 last flag");
    chk("R9 busy off after stop", int'(busy), 0);
    wr(1'b0, EN | CLR);
    wait_ticks(30);
    chk("R9 no further conversion", int'(done_flag), 0);
  endtask

  task automatic t_ext();
    smp[3] = 11'd1000;
    wr(1'b0, EN | AUT | CLR);
    wr(1'b1, 8'd3);
    wait_ticks(1);
    chk("R10 idle before trig", int'(busy), 0);
    pulse_trig();
    chk("R10 busy after trig", int'(busy), 1);
    wait_ticks(4);
    pulse_trig();
    wait_flag("R10 flag ext");
    chk("R10 ext result", int'(result), exp_code(1000));
    wr(1'b0, EN | AUT | CLR);
    wait_ticks(30);
    chk("R10 trig while busy ignored", int'(done_flag), 0);
    chk("R10 idle after ext", int'(busy), 0);
    wr(1'b0, EN | CLR);
    pulse_trig();
    chk("R10 trig with auto off", int'(busy), 0);
    wait_ticks(30);
    chk("R10 no flag with auto off", int'(done_flag), 0);
  endtask

  initial begin
    #(20 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    report();
    $finish;
  end

  initial begin
    for (int i = 0; i < NCH; i++) smp[i] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_track();
    t_single();
    t_freeze();
    t_sat();
    t_free();
    t_ext();
    report();
    $finish;
  end
endmodule